// File: doc/BRIEF.md
# Power-Up and Mute Sequencer

This block is the start-up and fault controller for a multi-channel volume-control core. It watches a raw supply-good flag, the active-low hardware mute pin and a handshake from the offset-calibration engine. From these inputs it drives a global reset, a hardware mute, a one-cycle calibration start and a one-cycle request that sets every channel gain code to zero, which is the software-muted code. The core's analog supply monitor and the calibration algorithm sit outside this block.

When the supply becomes good, the block holds reset and mute for a fixed number of clocks. It then releases reset and starts calibration. The next step ends either on the done handshake or when a watchdog expires. After a calibration at start-up, the block zeroes the gain codes and enters normal running. A supply drop in any state forces mute at once and sends the block back to the start of the sequence. While the block is running, asserting the mute pin starts a fresh calibration. That calibration returns straight to running and leaves the gain codes as they are.

Top module: `pwr_mute_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards for as long as the supply flag stays low, `sys_rst_o` and `hw_mute_o` are 1 and `cal_start_o` and `gain_clear_o` are 0. Whenever `sys_rst_o` is 1, `hw_mute_o` is 1.
- R2: The supply flag passes through a SYNC_STAGES-flop synchronizer. It counts as good only after the synchronized level has been high for DEB_CYCLES consecutive clocks. A shorter high pulse starts nothing.
- R3: After a rise on `supply_ok_i`, reset is held. `cal_start_o` then pulses for exactly one cycle, SYNC_STAGES+DEB_CYCLES+HOLD_CYCLES+1 clock cycles after the rise, in the same cycle in which `sys_rst_o` falls.
- R4: A calibration started at power-up ends in the cycle after `cal_done_i` is sampled high. `gain_clear_o` then pulses for one cycle while `hw_mute_o`=1 and `sys_rst_o`=0.
- R5: If `cal_done_i` does not arrive, calibration ends after CAL_TIMEOUT cycles, and `gain_clear_o` follows CAL_TIMEOUT cycles after `cal_start_o`.
- R6: In the cycle after the gain-clear pulse, the block is running: `sys_rst_o`=0, and `hw_mute_o`=0 when the mute pin is high.
- R7: If the supply input falls in any state, `hw_mute_o` rises SYNC_STAGES+1 cycles later and `sys_rst_o` rises one cycle after that.
- R8: When the supply recovers, the whole sequence runs again: hold, calibrate, gain clear, run.
- R9: While running, a falling `mute_n_i` raises `hw_mute_o` SYNC_STAGES cycles later and `cal_start_o` one cycle after that. When that calibration completes, the block returns to running with no gain-clear pulse.
- R10: Mute-pin edges that occur while a calibration is in progress are dropped. They do not start a later calibration.
- R11: While running, `hw_mute_o` follows the synchronized mute pin. Releasing the pin clears `hw_mute_o` SYNC_STAGES cycles later and starts no calibration.
- R12: A `cal_done_i` pulse outside calibration has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Raw supply-good flag from the analog monitor, asynchronous |
| mute_n_i | input | 1 | Hardware mute pin, active low, asynchronous |
| cal_done_i | input | 1 | Calibration engine finished |
| sys_rst_o | output | 1 | Global reset for the channel logic |
| hw_mute_o | output | 1 | Hardware mute of the outputs |
| cal_start_o | output | 1 | One-cycle offset-calibration start |
| gain_clear_o | output | 1 | One-cycle request to load 0x00 into every gain code |

## Verification
The bench measures the start-up latency to the exact cycle. It catches an off-by-one in the hold counter or the debounce, and it catches a supply pulse one cycle too short to count that is still taken as good. It sets the calibration done delay at random on both sides of the watchdog limit, so a watchdog that fires early or late, or a done pulse that is taken while the block runs, moves the gain-clear cycle or adds a pulse. It also toggles the mute pin during a calibration, which exposes a design that queues the request and runs a second calibration. Finally, it drops the supply in the middle of a calibration, which catches a design that finishes that calibration and clears the gains anyway.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [2:0] {
    SQ_UV_MUTE     = 3'd0,
    SQ_RESET_HOLD  = 3'd1,
    SQ_CALIBRATE   = 3'd2,
    SQ_CLEAR_GAINS = 3'd3,
    SQ_RUN         = 3'd4
  } sq_state_e;

  // larger of two counts, used to size the shared state timer
  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // true in the last cycle of a window of 'limit' cycles counted from zero
  function automatic logic at_limit(input logic [31:0] cnt, input int unsigned limit);
    return cnt == (limit - 1);
  endfunction

endpackage

// File: rtl/pms_sync.sv
module pms_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= {STAGES{RST_VAL}};
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/pms_debounce.sv
module pms_debounce #(
  parameter int DEB = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s,
  output logic good
);
  localparam int CW = (DEB > 1) ? $clog2(DEB) : 1;

  logic [CW-1:0] run_cnt;

  // drops at once, rises only after DEB consecutive high samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good    <= 1'b0;
      run_cnt <= '0;
    end else if (!s) begin
      good    <= 1'b0;
      run_cnt <= '0;
    end else if (!good) begin
      if (run_cnt == CW'(DEB - 1)) good <= 1'b1;
      else                         run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pms_timer.sv
module pms_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr)              cnt <= '0;
    else if (cnt != {W{1'b1}}) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwr_mute_seq.sv
module pwr_mute_seq
  import pms_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 20_000_000,
  parameter int unsigned CAL_TIMEOUT = 2_000_000,
  parameter int unsigned DEB_CYCLES  = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  input  logic mute_n_i,
  input  logic cal_done_i,
  output logic sys_rst_o,
  output logic hw_mute_o,
  output logic cal_start_o,
  output logic gain_clear_o
);
  localparam int unsigned CNT_MAX = max_u(HOLD_CYCLES, CAL_TIMEOUT);
  localparam int          CNT_W   = $clog2(CNT_MAX + 1);

  sq_state_e          state, nxt;
  logic [CNT_W-1:0]   cnt;
  logic               supply_s, supply_good_f;
  logic               mute_n_s, mute_act, mute_prev, mute_req;
  logic               from_pin, cal_start_q;
  logic               hold_done, cal_expired, cal_finish, state_change;

  pms_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sup_sync (
    .clk(clk), .rst_n(rst_n), .d(supply_ok_i), .q(supply_s));

  pms_debounce #(.DEB(DEB_CYCLES)) u_sup_deb (
    .clk(clk), .rst_n(rst_n), .s(supply_s), .good(supply_good_f));

  pms_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_mute_sync (
    .clk(clk), .rst_n(rst_n), .d(mute_n_i), .q(mute_n_s));

  pms_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(state_change), .cnt(cnt));

  // named internal events
  assign mute_act     = ~mute_n_s;
  assign mute_req     = mute_act & ~mute_prev;
  assign hold_done    = at_limit(32'(cnt), HOLD_CYCLES);
  assign cal_expired  = at_limit(32'(cnt), CAL_TIMEOUT);
  assign cal_finish   = cal_done_i | cal_expired;
  assign state_change = (nxt != state);

  always_comb begin
    nxt = state;
    if (!supply_good_f) begin
      nxt = SQ_UV_MUTE;
    end else begin
      unique case (state)
        SQ_UV_MUTE:     nxt = SQ_RESET_HOLD;
        SQ_RESET_HOLD:  if (hold_done) nxt = SQ_CALIBRATE;
        SQ_CALIBRATE:   if (cal_finish) nxt = from_pin ? SQ_RUN : SQ_CLEAR_GAINS;
        SQ_CLEAR_GAINS: nxt = SQ_RUN;
        SQ_RUN:         if (mute_req) nxt = SQ_CALIBRATE;
        default:        nxt = SQ_UV_MUTE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= SQ_UV_MUTE;
      from_pin    <= 1'b0;
      cal_start_q <= 1'b0;
      mute_prev   <= 1'b0;
    end else begin
      state       <= nxt;
      mute_prev   <= mute_act;
      cal_start_q <= (nxt == SQ_CALIBRATE) && (state != SQ_CALIBRATE);
      if ((nxt == SQ_CALIBRATE) && (state != SQ_CALIBRATE))
        from_pin <= (state == SQ_RUN);
    end
  end

  assign sys_rst_o    = (state == SQ_UV_MUTE) || (state == SQ_RESET_HOLD);
  assign hw_mute_o    = (state != SQ_RUN) || !supply_good_f || mute_act;
  assign cal_start_o  = cal_start_q;
  assign gain_clear_o = (state == SQ_CLEAR_GAINS);
endmodule

// File: rtl/pwr_mute_seq_chk.sv
module pwr_mute_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic sys_rst,
  input logic hw_mute,
  input logic cal_start,
  input logic gain_clear,
  input logic supply_good
);
  AST_RST_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> hw_mute) else $error("reset without mute"); // R1
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_start) else $error("cal start longer than one cycle"); // R3
  AST_RELEASE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> cal_start) else $error("reset released without calibration"); // R3
  AST_CLEAR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    gain_clear |=> !gain_clear) else $error("gain clear longer than one cycle"); // R4
  AST_CLEAR_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    gain_clear |-> (hw_mute && !sys_rst)) else $error("gain clear outside muted run-up"); // R4
  AST_CAL_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> (hw_mute && !sys_rst)) else $error("calibration while unmuted"); // R9
  AST_UV_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_good |-> hw_mute) else $error("unmuted on bad supply"); // R7
  AST_UV_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(supply_good) |=> sys_rst) else $error("no reset after supply loss"); // R7
endmodule

bind pwr_mute_seq pwr_mute_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst_o), .hw_mute(hw_mute_o),
  .cal_start(cal_start_o), .gain_clear(gain_clear_o), .supply_good(supply_good_f));

// File: tb/pwr_mute_seq_tb_top.sv
`timescale 1ns/1ps
module pwr_mute_seq_tb_top;
  localparam int HOLD = 40;
  localparam int TO   = 24;
  localparam int DEB  = 4;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n, supply, mute_n, cal_done;
  logic sys_rst, hw_mute, cal_start, gain_clear;
  int   n_chk = 0, n_fail = 0, cs_cnt = 0, gc_cnt = 0;

  always #2.5 clk = ~clk;

  pwr_mute_seq #(.HOLD_CYCLES(HOLD), .CAL_TIMEOUT(TO), .DEB_CYCLES(DEB), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok_i(supply), .mute_n_i(mute_n), .cal_done_i(cal_done),
    .sys_rst_o(sys_rst), .hw_mute_o(hw_mute), .cal_start_o(cal_start), .gain_clear_o(gain_clear));

  always @(negedge clk) begin
    if (cal_start) cs_cnt++;
    if (gain_clear) gc_cnt++;
  end

  function automatic int exp_start_lat();
    return SYNC + DEB + HOLD + 1;
  endfunction
  function automatic int exp_clear_lat(input int d);
    return (d + 1 < TO) ? d + 1 : TO;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // raise the supply and measure the reset hold up to the calibration start
  task automatic power_up(input string req);
    int k = 0;
    bit seen = 0, held = 1;
    @(negedge clk); supply = 1'b1;
    while (!seen && k < 400) begin
      @(negedge clk); k++;
      if (cal_start) seen = 1;
      else if (!sys_rst) held = 0;
    end
    chk(req, "cal start latency", k, exp_start_lat());
    chk(req, "reset held through hold", int'(held), 1);
    chk(req, "reset released with start", int'(sys_rst), 0);
  endtask

  // finish a power-up calibration with done after d cycles (d may exceed watchdog)
  task automatic finish_cal(input int d, input string req);
    int first = -1, highs = 0;
    cal_done = (d == 0);
    for (int j = 1; j <= TO + 8; j++) begin
      @(negedge clk);
      if (gain_clear) begin
        highs++;
        if (first < 0) first = j;
      end
      cal_done = (j == d);
    end
    cal_done = 1'b0;
    chk(req, "gain clear cycle", first, exp_clear_lat(d));
    chk(req, "gain clear pulse count", highs, 1);
    chk("R6", "run unmuted", int'(hw_mute), 0);
    chk("R6", "run out of reset", int'(sys_rst), 0);
  endtask

  task automatic drop_supply(input bit running);
    @(negedge clk); supply = 1'b0;
    wait_neg(2);
    if (running) chk("R7", "mute not yet", int'(hw_mute), 0);
    wait_neg(1);
    chk("R7", "mute after drop", int'(hw_mute), 1);
    wait_neg(1);
    chk("R7", "reset after drop", int'(sys_rst), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cs0, gc0, d, len;
    void'($urandom(32'd7301));
    rst_n = 1'b0; supply = 1'b0; mute_n = 1'b1; cal_done = 1'b0;
    wait_neg(4);
    chk("R1", "reset in reset", int'(sys_rst), 1);
    chk("R1", "mute in reset", int'(hw_mute), 1);
    chk("R1", "no start in reset", int'(cal_start), 0);
    chk("R1", "no clear in reset", int'(gain_clear), 0);
    rst_n = 1'b1;
    wait_neg(10);
    chk("R1", "reset with supply low", int'(sys_rst), 1);

    // R2: short supply pulse
    supply = 1'b1; wait_neg(DEB - 1); supply = 1'b0;
    wait_neg(HOLD + 20);
    chk("R2", "short pulse starts nothing", cs_cnt, 0);
    chk("R2", "still in reset", int'(sys_rst), 1);

    power_up("R3");
    finish_cal(5, "R4");

    // R12: stray done while running
    cs0 = cs_cnt; gc0 = gc_cnt;
    cal_done = 1'b1; wait_neg(3); cal_done = 1'b0; wait_neg(10);
    chk("R12", "no clear from stray done", gc_cnt, gc0);
    chk("R12", "no start from stray done", cs_cnt, cs0);
    chk("R12", "still unmuted", int'(hw_mute), 0);

    // R9, R11: mute pin held through calibration
    cs0 = cs_cnt; gc0 = gc_cnt;
    mute_n = 1'b0;
    wait_neg(1); chk("R11", "mute not yet", int'(hw_mute), 0);
    wait_neg(1); chk("R9", "mute follows pin", int'(hw_mute), 1);
    wait_neg(1); chk("R9", "cal start after pin", int'(cal_start), 1);
    wait_neg(5); cal_done = 1'b1; wait_neg(1); cal_done = 1'b0;
    wait_neg(4);
    chk("R11", "held pin keeps mute", int'(hw_mute), 1);
    chk("R9", "no gain clear after pin cal", gc_cnt, gc0);
    chk("R9", "not in reset", int'(sys_rst), 0);
    mute_n = 1'b1;
    wait_neg(1); chk("R11", "mute before sync", int'(hw_mute), 1);
    wait_neg(1); chk("R11", "release unmutes", int'(hw_mute), 0);
    wait_neg(10);
    chk("R11", "release starts no cal", cs_cnt, cs0 + 1);

    // R10: pin toggles during a calibration
    cs0 = cs_cnt;
    mute_n = 1'b0;
    wait_neg(3); chk("R10", "cal start", int'(cal_start), 1);
    wait_neg(1); mute_n = 1'b1;
    wait_neg(3); mute_n = 1'b0;
    wait_neg(3); mute_n = 1'b1;
    wait_neg(5); cal_done = 1'b1; wait_neg(1); cal_done = 1'b0;
    wait_neg(30);
    chk("R10", "request in cal dropped", cs_cnt, cs0 + 1);
    chk("R10", "running unmuted", int'(hw_mute), 0);

    // R5, R8: supply loss from run, then watchdog
    drop_supply(1);
    wait_neg(5);
    power_up("R8");
    finish_cal(TO + 3, "R5");

    // R7: supply loss during calibration
    drop_supply(1);
    wait_neg(5);
    power_up("R8");
    gc0 = gc_cnt;
    drop_supply(0);
    wait_neg(TO + 5);
    chk("R7", "aborted cal clears nothing", gc_cnt, gc0);
    chk("R7", "aborted cal stays muted", int'(hw_mute), 1);
    power_up("R8");
    finish_cal(TO - 1, "R5");

    // random rounds: glitch, restart, random done delay
    for (int it = 0; it < 10; it++) begin
      drop_supply(1);
      len = 1 + int'($urandom_range(DEB - 2));
      wait_neg(4);
      supply = 1'b1; wait_neg(len); supply = 1'b0;
      wait_neg(HOLD + 10);
      chk("R2", "random glitch keeps reset", int'(sys_rst), 1);
      d = int'($urandom_range(TO + 4));
      power_up("R8");
      finish_cal(d, "R4");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule